// File: doc/BRIEF.md
# Six-Step BLDC Commutation Decoder

This block drives the three half-bridges of a brushless DC motor from one PWM signal and a 3-bit rotor position code. The code can come from the motor's Hall sensors or from a controller that steps through the positions itself. A fixed six-step block-commutation table picks one phase to be switched by the PWM and one phase whose low switch is held on as the current return. The third phase floats. The one PWM input sets both the switching frequency and the duty cycle of whichever half-bridge is active.

Three further inputs shape the result. A direction input reverses rotation by looking up the table with the complement of the position code. An active-low brake input turns on all three low switches and turns off all three high switches, overriding everything else. A static mode input chooses how the PWM-driven phase recirculates. In synchronous mode its low switch is driven with the inverse of PWM. In asynchronous mode its low switch stays off.

The position, direction and brake inputs are each synchronized through a two-flop chain. The six gate enables are registered, so the outputs change only on a clock edge. Dead time, protection and current sensing are handled elsewhere.

Top module: `bldc_sixstep_dec`

## Requirements
- R1: While `rst` is high, all six gate outputs are low. They stay low until a decoded position code first reaches them.
- R2: Position code 000 (`hall_in[2]`=A, `hall_in[1]`=B, `hall_in[0]`=C) turns all six gate outputs off. This holds for either direction, either mode and either PWM level.
- R3: Position code 111 aligns the rotor for either direction. Phase A's high switch follows PWM. Phases B and C have their high switches off and their low switches on. Phase A's low switch follows the rule of R6 or R7.
- R4: With `dir_in` low, the codes map to a (PWM phase, return phase) pair: 110→(B,C), 100→(A,C), 101→(A,B), 001→(C,B), 011→(C,A), 010→(B,A). The phase not named has both switches off. Gate index 0 is phase A, index 1 is phase B and index 2 is phase C.
- R5: With `dir_in` high, a code other than 000 and 111 selects the pair that its bitwise complement selects under R4. For example, 001 gives (B,C).
- R6: With `async_mode` low, the low switch of the PWM phase carries the inverse of PWM, and its high switch carries PWM.
- R7: With `async_mode` high, the low switch of the PWM phase stays off. The low switch of the return phase stays on.
- R8: While the synchronized `brake_n` is low, `gate_hi` is 000 and `gate_lo` is 111, whatever the other inputs are.
- R9: A PWM change reaches the outputs on the first rising edge after it. A change of the position, direction or brake input reaches the outputs on the third rising edge, and not before.
- R10: No phase has its high and low outputs both on in any cycle. At most one high output is on at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM that switches the active half-bridge |
| hall_in | input | 3 | Rotor position code: bit 2 is A, bit 1 is B, bit 0 is C |
| dir_in | input | 1 | Rotation direction; high selects the complemented table |
| brake_n | input | 1 | Active-low brake |
| async_mode | input | 1 | Static recirculation select: 1 is asynchronous, 0 is synchronous |
| gate_hi | output | 3 | High-switch enables for phases C, B, A (bits 2..0) |
| gate_lo | output | 3 | Low-switch enables for phases C, B, A (bits 2..0) |

## Verification
The hardest case to reach from the ports is a position change that lands while the PWM phase is moving. The synchronizer delays the position by two more edges than the PWM, so the outputs go through cycles that mix the old position with the new PWM level. The stimulus holds each input pattern until it has settled, then steps only the PWM or only the position at a falling edge. The scoreboard queues the old and new expected gates for the exact edges at which each should appear. An exhaustive sweep covers every code under both directions, both modes, both PWM levels and both brake levels.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

    localparam int NPH      = 3;
    localparam int CODE_W   = NPH;
    localparam int PH_IDX_W = $clog2(NPH);

    typedef enum logic [PH_IDX_W-1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        K_STOP  = 2'd0,
        K_ALIGN = 2'd1,
        K_COMM  = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e  kind;
        phase_e drv;   // phase switched by PWM
        phase_e ret;   // phase whose low switch is held on
    } step_t;

    typedef struct packed {
        logic [NPH-1:0] hi;
        logic [NPH-1:0] lo;
    } gates_t;

    localparam logic [CODE_W-1:0] CODE_STOP  = '0;
    localparam logic [CODE_W-1:0] CODE_ALIGN = '1;

    // Forward table; reverse direction looks it up with the complemented code.
    function automatic step_t decode_step(input logic [CODE_W-1:0] code,
                                          input logic rev);
        step_t s;
        logic [CODE_W-1:0] c;
        s.kind = K_STOP;
        s.drv  = PH_A;
        s.ret  = PH_A;
        if (code == CODE_ALIGN) begin
            s.kind = K_ALIGN;
            s.drv  = PH_A;
            s.ret  = PH_B;
        end else if (code != CODE_STOP) begin
            c = rev ? ~code : code;
            s.kind = K_COMM;
            case (c)
                3'b110:  begin s.drv = PH_B; s.ret = PH_C; end
                3'b100:  begin s.drv = PH_A; s.ret = PH_C; end
                3'b101:  begin s.drv = PH_A; s.ret = PH_B; end
                3'b001:  begin s.drv = PH_C; s.ret = PH_B; end
                3'b011:  begin s.drv = PH_C; s.ret = PH_A; end
                3'b010:  begin s.drv = PH_B; s.ret = PH_A; end
                default: s.kind = K_STOP;
            endcase
        end
        return s;
    endfunction

    function automatic gates_t build_gates(input step_t s,
                                           input logic pwm,
                                           input logic async_m,
                                           input logic braking);
        gates_t g;
        g.hi = '0;
        g.lo = '0;
        if (braking) begin
            g.lo = '1;
        end else begin
            case (s.kind)
                K_ALIGN: begin
                    g.hi[PH_A] = pwm;
                    g.lo[PH_A] = ~pwm & ~async_m;
                    g.lo[PH_B] = 1'b1;
                    g.lo[PH_C] = 1'b1;
                end
                K_COMM: begin
                    g.hi[s.drv] = pwm;
                    g.lo[s.drv] = ~pwm & ~async_m;
                    g.lo[s.ret] = 1'b1;
                end
                default: ;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= RST_VAL;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ss_step_lut.sv
module ss_step_lut
    import sixstep_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              rev_i,
    output step_t             step_o
);
    always_comb step_o = decode_step(code_i, rev_i);
endmodule

// File: rtl/ss_gate_reg.sv
module ss_gate_reg
    import sixstep_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  step_t  step_i,
    input  logic   pwm_i,
    input  logic   async_i,
    input  logic   brake_n_i,
    output gates_t gates_o
);
    gates_t gates_q;
    gates_t gates_d;

    always_comb gates_d = build_gates(step_i, pwm_i, async_i, ~brake_n_i);

    always_ff @(posedge clk) begin
        if (rst) gates_q <= '0;
        else     gates_q <= gates_d;
    end

    assign gates_o = gates_q;

    // R8
    brake_force_chk: assert property (@(posedge clk) disable iff (rst)
        !brake_n_i |=> (gates_q.hi == '0) && (gates_q.lo == '1));

    // R2
    stop_off_chk: assert property (@(posedge clk) disable iff (rst)
        (brake_n_i && step_i.kind == K_STOP) |=> (gates_q.hi == '0) && (gates_q.lo == '0));

    // R7
    async_lo_off_chk: assert property (@(posedge clk) disable iff (rst)
        (brake_n_i && async_i && step_i.kind == K_COMM)
        |=> !gates_q.lo[$past(step_i.drv)] && gates_q.lo[$past(step_i.ret)]);

    // R9
    pwm_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (brake_n_i && step_i.kind != K_STOP)
        |=> gates_q.hi[$past(step_i.drv)] == $past(pwm_i));

    // R6
    sync_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (brake_n_i && !async_i && step_i.kind != K_STOP)
        |=> gates_q.lo[$past(step_i.drv)] == !$past(pwm_i));
endmodule

// File: rtl/bldc_sixstep_dec.sv
module bldc_sixstep_dec
    import sixstep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwm_in,
    input  logic [2:0] hall_in,
    input  logic       dir_in,
    input  logic       brake_n,
    input  logic       async_mode,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo
);
    localparam int SYN_W = CODE_W + 2;
    // Position resets to stop, brake resets to released.
    localparam logic [SYN_W-1:0] SYN_RST = {{CODE_W{1'b0}}, 1'b0, 1'b1};

    logic [SYN_W-1:0] syn_q;
    logic [CODE_W-1:0] code_s;
    logic              dir_s;
    logic              brake_n_s;
    step_t             step;
    gates_t            gates;

    ss_sync #(
        .W       (SYN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({hall_in, dir_in, brake_n}),
        .q   (syn_q)
    );

    assign code_s    = syn_q[SYN_W-1:2];
    assign dir_s     = syn_q[1];
    assign brake_n_s = syn_q[0];

    ss_step_lut u_lut (
        .code_i (code_s),
        .rev_i  (dir_s),
        .step_o (step)
    );

    ss_gate_reg u_gate (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step),
        .pwm_i     (pwm_in),
        .async_i   (async_mode),
        .brake_n_i (brake_n_s),
        .gates_o   (gates)
    );

    assign gate_hi = gates.hi;
    assign gate_lo = gates.lo;

    for (genvar p = 0; p < NPH; p++) begin : g_phase_chk
        // R10
        no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
            !(gate_hi[p] && gate_lo[p]));
    end

    // R10
    one_high_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_hi));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (gate_hi == '0) && (gate_lo == '0));
endmodule

// File: tb/bldc_sixstep_dec_tb.sv
`timescale 1ns/1ps
module bldc_sixstep_dec_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic [2:0] hall_in = 3'b000;
    logic       dir_in = 1'b0;
    logic       brake_n = 1'b1;
    logic       async_mode = 1'b0;
    logic [2:0] gate_hi;
    logic [2:0] gate_lo;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    bldc_sixstep_dec u_dut (
        .clk        (clk),
        .rst        (rst),
        .pwm_in     (pwm_in),
        .hall_in    (hall_in),
        .dir_in     (dir_in),
        .brake_n    (brake_n),
        .async_mode (async_mode),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo)
    );

    // Expected gates from the requirement text (index 0=A, 1=B, 2=C).
    function automatic void model(input logic pwm, input logic [2:0] code,
                                  input logic dir, input logic brk_n,
                                  input logic am,
                                  output logic [2:0] hi, output logic [2:0] lo);
        int d, r;
        logic [2:0] c;
        hi = 3'b000;
        lo = 3'b000;
        d = -1;
        r = -1;
        if (!brk_n) begin
            lo = 3'b111;
            return;
        end
        if (code == 3'b000) return;
        if (code == 3'b111) begin
            hi[0] = pwm;
            lo[0] = !pwm && !am;
            lo[1] = 1'b1;
            lo[2] = 1'b1;
            return;
        end
        c = dir ? ~code : code;
        case (c)
            3'b110: begin d = 1; r = 2; end
            3'b100: begin d = 0; r = 2; end
            3'b101: begin d = 0; r = 1; end
            3'b001: begin d = 2; r = 1; end
            3'b011: begin d = 2; r = 0; end
            3'b010: begin d = 1; r = 0; end
            default: ;
        endcase
        hi[d] = pwm;
        lo[d] = !pwm && !am;
        lo[r] = 1'b1;
    endfunction

    task automatic push_exp(input logic pwm, input logic [2:0] code,
                            input logic dir, input logic brk_n,
                            input logic am, input string tag);
        exp_t e;
        model(pwm, code, dir, brk_n, am, e.hi, e.lo);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic push_raw(input logic [2:0] hi, input logic [2:0] lo,
                            input string tag);
        exp_t e;
        e.hi = hi;
        e.lo = lo;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Apply a full pattern and check after it has settled.
    task automatic apply(input logic pwm, input logic [2:0] code,
                         input logic dir, input logic brk_n,
                         input logic am, input string tag);
        @(negedge clk);
        pwm_in = pwm;
        hall_in = code;
        dir_in = dir;
        brake_n = brk_n;
        async_mode = am;
        repeat (3) @(posedge clk);
        @(negedge clk);
        push_exp(pwm, code, dir, brk_n, am, tag);
    endtask

    // R9: PWM reaches outputs after one rising edge.
    task automatic pwm_step(input logic pwm);
        logic old;
        old = pwm_in;
        @(negedge clk);
        pwm_in = pwm;
        push_exp(old, hall_in, dir_in, brake_n, async_mode, "R9 pwm before edge");
        @(posedge clk);
        @(negedge clk);
        push_exp(pwm, hall_in, dir_in, brake_n, async_mode, "R9 pwm after edge");
    endtask

    // R9: position reaches outputs on the third rising edge.
    task automatic hall_step(input logic [2:0] code);
        logic [2:0] old;
        old = hall_in;
        @(negedge clk);
        hall_in = code;
        repeat (2) @(posedge clk);
        @(negedge clk);
        push_exp(pwm_in, old, dir_in, brake_n, async_mode, "R9 hall after 2 edges");
        @(posedge clk);
        @(negedge clk);
        push_exp(pwm_in, code, dir_in, brake_n, async_mode, "R9 hall after 3 edges");
    endtask

    // Scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (gate_hi !== e.hi || gate_lo !== e.lo) begin
                    fails++;
                    $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                             e.tag, gate_hi, gate_lo, e.hi, e.lo);
                end
                checks++;
                if ((gate_hi & gate_lo) !== 3'b000) begin
                    fails++;
                    $display("FAIL R10 (%s): hi&lo=%b expected 000",
                             e.tag, gate_hi & gate_lo);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        string tag;
        // R1: reset state with active inputs.
        pwm_in = 1'b1;
        hall_in = 3'b110;
        repeat (3) @(posedge clk);
        @(negedge clk);
        push_raw(3'b000, 3'b000, "R1 during reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        push_raw(3'b000, 3'b000, "R1 first cycle after reset");
        @(posedge clk);
        @(negedge clk);
        push_raw(3'b000, 3'b000, "R1/R9 second cycle after reset");
        @(posedge clk);
        @(negedge clk);
        push_exp(1'b1, 3'b110, 1'b0, 1'b1, 1'b0, "R9 first decode after reset");

        // Exhaustive sweep.
        for (int am = 0; am < 2; am++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int brk = 0; brk < 2; brk++) begin
                    for (int code = 0; code < 8; code++) begin
                        for (int p = 0; p < 2; p++) begin
                            if (brk == 0)          tag = "R8 brake";
                            else if (code == 0)    tag = "R2 stop";
                            else if (code == 7)    tag = am ? "R3/R7 align" : "R3/R6 align";
                            else if (dir == 1)     tag = am ? "R5/R7 reverse" : "R5/R6 reverse";
                            else                   tag = am ? "R4/R7 forward" : "R4/R6 forward";
                            apply(p[0], code[2:0], dir[0], brk[0], am[0], tag);
                        end
                    end
                end
            end
        end

        // R5 spot checks from the example pair.
        apply(1'b1, 3'b001, 1'b1, 1'b1, 1'b0, "R5 code 001 reversed");
        apply(1'b1, 3'b110, 1'b1, 1'b1, 1'b0, "R5 code 110 reversed");

        // R9 timing of PWM and position.
        apply(1'b0, 3'b100, 1'b0, 1'b1, 1'b0, "R4 setup");
        pwm_step(1'b1);
        pwm_step(1'b0);
        hall_step(3'b101);
        hall_step(3'b001);
        hall_step(3'b000);
        hall_step(3'b111);

        // R8 brake priority and release timing.
        apply(1'b1, 3'b011, 1'b0, 1'b1, 1'b1, "R7 setup");
        @(negedge clk);
        brake_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        push_exp(1'b1, 3'b011, 1'b0, 1'b1, 1'b1, "R9 brake after 2 edges");
        @(posedge clk);
        @(negedge clk);
        push_raw(3'b000, 3'b111, "R8 brake after 3 edges");
        pwm_step(1'b0);
        @(negedge clk);
        hall_in = 3'b110;
        dir_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        push_raw(3'b000, 3'b111, "R8 brake overrides hall/dir change");
        @(negedge clk);
        brake_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        push_exp(1'b0, 3'b110, 1'b1, 1'b1, 1'b1, "R8 release");

        repeat (3) @(negedge clk);
        #2;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule